// File: doc/BRIEF.md
# In-Band Control Cell Engine

This block sits in a switch port processor and services configuration and statistics requests that arrive as ordinary cells. A cell whose header equals a reserved virtual-path/virtual-channel value is a control cell. Its payload names a target port, an operation, a table index and a data word. When the local port is the target and control reception is enabled, the engine performs the operation. The operations are a read or write of the VC routing table, a write or read of a hardware option register, and a read of a link counter or a per-VC cell counter. Each read returns a reply cell on the output. When another port is the target, the engine sends the cell on unchanged toward that port.

The engine handles one cell at a time and is driven by a single state machine. Its states are `ST_IDLE`, `ST_DECODE`, `ST_FWD`, `ST_TBL_WR`, `ST_TBL_RD`, `ST_TBL_WAIT`, `ST_OPT_WR`, `ST_CNT_RD`, `ST_CNT_WAIT` and `ST_REPLY`.

- `ST_IDLE` accepts a cell and moves to `ST_DECODE`.
- `ST_DECODE` returns to `ST_IDLE` for a non-control cell, when control reception is disabled, or for an unknown opcode. Otherwise it moves to one of:
  - `ST_FWD` for a cell addressed to another port;
  - `ST_TBL_WR` or `ST_TBL_RD` for table operations;
  - `ST_OPT_WR` for an option write;
  - `ST_REPLY` for an option read;
  - `ST_CNT_RD` for a counter read.
- `ST_TBL_RD` moves to `ST_TBL_WAIT`, and `ST_CNT_RD` moves to `ST_CNT_WAIT`. Both wait states then move to `ST_REPLY`.
- `ST_FWD`, `ST_TBL_WR`, `ST_OPT_WR` and `ST_REPLY` all return to `ST_IDLE`.

The routing table port and the counter bank are both external, and both return read data one cycle after the request. A free-running timestamp counter is sampled in the same cycle that the counter read is issued. The reply therefore pairs the counter value with the exact moment it was taken, so software can measure load over short intervals.

Top module: `ctl_cell_engine`

## Requirements
- R1: Only a cell whose `in_hdr` equals parameter `CTRL_HDR` is treated as a control cell. Any other cell produces no output, no table access and no option change.
- R2: While `ctrl_en` is 0, control cells produce no output, no table write and no change to `hw_opts`.
- R3: A control cell whose `in_target` differs from `port_id` is emitted once, with header, opcode, target, index and data unchanged and `out_stamp` 0. No local action is taken.
- R4: Opcode 0x02 (table write) issues one `rt_req` cycle with `rt_we`=1, `rt_addr`=index and `rt_wdata`=data. It produces no reply.
- R5: Opcode 0x01 (table read) issues one `rt_req` cycle with `rt_we`=0. It replies with the entry value in `out_data`.
- R6: Opcode 0x03 sets `hw_opts` to the low `OPT_W` bits of the data. Opcode 0x04 replies with the current `hw_opts`, zero-extended.
- R7: Opcode 0x05 issues `cnt_rd` with `cnt_per_vc`=0, and opcode 0x06 issues it with `cnt_per_vc`=1. In both cases `cnt_idx` is the index, and the reply carries the returned counter value.
- R8: The timestamp is 0 during reset and counts up by one per clock, modulo 2^`TS_W`. A counter reply carries in `out_stamp` the timestamp of the cycle in which `cnt_rd` was high. Non-counter replies carry stamp 0.
- R9: A reply uses header `CTRL_HDR`, opcode = request opcode OR 0x80, target field = `port_id`, and the echoed index.
- R10: Any opcode other than 0x01 to 0x06 addressed to this port is ignored: no output, no table or counter access, no option change.
- R11: After reset, `in_ready`=1, `out_valid`=0 and `hw_opts`=0. `in_ready` is high only while idle, and each output cell lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_id | input | 8 | Number of this port |
| ctrl_en | input | 1 | Control reception enable |
| in_valid | input | 1 | Input cell present |
| in_ready | output | 1 | Engine idle, cell accepted |
| in_hdr | input | HDR_W | Cell VPI/VCI header |
| in_opcode | input | 8 | Payload operation code |
| in_target | input | 8 | Payload target port |
| in_index | input | IDX_W | Payload table/counter index |
| in_data | input | DATA_W | Payload write data |
| out_valid | output | 1 | Output cell present (one cycle) |
| out_hdr | output | HDR_W | Output header |
| out_opcode | output | 8 | Output opcode |
| out_target | output | 8 | Output target/source port |
| out_index | output | IDX_W | Output index |
| out_data | output | DATA_W | Output data |
| out_stamp | output | TS_W | Counter snapshot timestamp |
| rt_req | output | 1 | Routing table access strobe |
| rt_we | output | 1 | Routing table write enable |
| rt_addr | output | IDX_W | Routing table entry index |
| rt_wdata | output | DATA_W | Routing table write data |
| rt_rdata | input | DATA_W | Routing table read data (1-cycle latency) |
| cnt_rd | output | 1 | Counter read strobe |
| cnt_per_vc | output | 1 | 1 selects per-VC counter, 0 link counter |
| cnt_idx | output | IDX_W | Counter index |
| cnt_rdata | input | DATA_W | Counter value (1-cycle latency) |
| hw_opts | output | OPT_W | Hardware option register |

## Verification
The bench sets `TS_W`=8, `CTRL_HDR`=24'hABC1 and `port_id`=3, and keeps the defaults for the 32-bit data and 8-bit index widths. The narrow timestamp lets a run of a few hundred cycles reach a counter read taken after the stamp has wrapped. The 8-bit index reaches the top table entry, 0xFF.

The bench's counter bank encodes the read cycle into each counter value. A reply whose data and stamp come from different cycles is therefore caught. Disabled, misaddressed, non-control and unknown-opcode cells are all checked by reading the table and `hw_opts` back afterwards, and by confirming that no unexpected cell appears on the output.

// File: rtl/cce_pkg.sv
package cce_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DECODE,
        ST_FWD,
        ST_TBL_WR,
        ST_TBL_RD,
        ST_TBL_WAIT,
        ST_OPT_WR,
        ST_CNT_RD,
        ST_CNT_WAIT,
        ST_REPLY
    } cce_state_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_TBL_RD,
        K_TBL_WR,
        K_OPT_WR,
        K_OPT_RD,
        K_LINK_CNT,
        K_VC_CNT
    } cce_kind_e;

    localparam logic [7:0] OPC_TBL_RD   = 8'h01;
    localparam logic [7:0] OPC_TBL_WR   = 8'h02;
    localparam logic [7:0] OPC_OPT_WR   = 8'h03;
    localparam logic [7:0] OPC_OPT_RD   = 8'h04;
    localparam logic [7:0] OPC_LINK_CNT = 8'h05;
    localparam logic [7:0] OPC_VC_CNT   = 8'h06;
    localparam logic [7:0] OPC_RSP_FLAG = 8'h80;

endpackage

// File: rtl/cce_decode.sv
module cce_decode
    import cce_pkg::*;
#(
    parameter int          HDR_W    = 24,
    parameter logic [HDR_W-1:0] CTRL_HDR = 24'h00001F
) (
    input  logic [HDR_W-1:0] hdr,
    input  logic [7:0]       opcode,
    input  logic [7:0]       target,
    input  logic [7:0]       port_id,
    output logic             is_ctrl,
    output logic             for_me,
    output cce_kind_e        kind
);

    assign is_ctrl = (hdr == CTRL_HDR);
    assign for_me  = (target == port_id);

    always_comb begin
        case (opcode)
            OPC_TBL_RD:   kind = K_TBL_RD;
            OPC_TBL_WR:   kind = K_TBL_WR;
            OPC_OPT_WR:   kind = K_OPT_WR;
            OPC_OPT_RD:   kind = K_OPT_RD;
            OPC_LINK_CNT: kind = K_LINK_CNT;
            OPC_VC_CNT:   kind = K_VC_CNT;
            default:      kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/cce_stamp.sv
module cce_stamp #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts
);

    localparam logic [TS_W-1:0] TS_STEP = 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts <= '0;
        else        ts <= ts + TS_STEP;
    end

    // R8
    ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (ts == $past(ts) + TS_STEP));

endmodule

// File: rtl/ctl_cell_engine.sv
module ctl_cell_engine
    import cce_pkg::*;
#(
    parameter int               HDR_W    = 24,
    parameter logic [HDR_W-1:0] CTRL_HDR = 24'h00001F,
    parameter int               IDX_W    = 8,
    parameter int               DATA_W   = 32,
    parameter int               TS_W     = 32,
    parameter int               OPT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        port_id,
    input  logic              ctrl_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [HDR_W-1:0]  in_hdr,
    input  logic [7:0]        in_opcode,
    input  logic [7:0]        in_target,
    input  logic [IDX_W-1:0]  in_index,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [HDR_W-1:0]  out_hdr,
    output logic [7:0]        out_opcode,
    output logic [7:0]        out_target,
    output logic [IDX_W-1:0]  out_index,
    output logic [DATA_W-1:0] out_data,
    output logic [TS_W-1:0]   out_stamp,
    output logic              rt_req,
    output logic              rt_we,
    output logic [IDX_W-1:0]  rt_addr,
    output logic [DATA_W-1:0] rt_wdata,
    input  logic [DATA_W-1:0] rt_rdata,
    output logic              cnt_rd,
    output logic              cnt_per_vc,
    output logic [IDX_W-1:0]  cnt_idx,
    input  logic [DATA_W-1:0] cnt_rdata,
    output logic [OPT_W-1:0]  hw_opts
);

    localparam int PAD_W = DATA_W - OPT_W;

    cce_state_e         state, next_state;
    logic [HDR_W-1:0]   hdr_q;
    logic [7:0]         op_q;
    logic [7:0]         tgt_q;
    logic [IDX_W-1:0]   idx_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  rsp_data_q;
    logic [TS_W-1:0]    rsp_stamp_q;
    logic [OPT_W-1:0]   opts_q;
    logic [TS_W-1:0]    ts;
    logic               is_ctrl, for_me;
    cce_kind_e          kind;

    cce_decode #(.HDR_W(HDR_W), .CTRL_HDR(CTRL_HDR)) u_decode (
        .hdr     (hdr_q),
        .opcode  (op_q),
        .target  (tgt_q),
        .port_id (port_id),
        .is_ctrl (is_ctrl),
        .for_me  (for_me),
        .kind    (kind)
    );

    cce_stamp #(.TS_W(TS_W)) u_stamp (
        .clk   (clk),
        .rst_n (rst_n),
        .ts    (ts)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    // Transitions
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:     if (in_valid) next_state = ST_DECODE;
            ST_DECODE: begin
                if (!is_ctrl || !ctrl_en) next_state = ST_IDLE;
                else if (!for_me)         next_state = ST_FWD;
                else begin
                    case (kind)
                        K_TBL_WR:   next_state = ST_TBL_WR;
                        K_TBL_RD:   next_state = ST_TBL_RD;
                        K_OPT_WR:   next_state = ST_OPT_WR;
                        K_OPT_RD:   next_state = ST_REPLY;
                        K_LINK_CNT: next_state = ST_CNT_RD;
                        K_VC_CNT:   next_state = ST_CNT_RD;
                        default:    next_state = ST_IDLE;
                    endcase
                end
            end
            ST_FWD:      next_state = ST_IDLE;
            ST_TBL_WR:   next_state = ST_IDLE;
            ST_TBL_RD:   next_state = ST_TBL_WAIT;
            ST_TBL_WAIT: next_state = ST_REPLY;
            ST_OPT_WR:   next_state = ST_IDLE;
            ST_CNT_RD:   next_state = ST_CNT_WAIT;
            ST_CNT_WAIT: next_state = ST_REPLY;
            ST_REPLY:    next_state = ST_IDLE;
            default:     next_state = ST_IDLE;
        endcase
    end

    // Captured cell fields and reply data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q       <= '0;
            op_q        <= '0;
            tgt_q       <= '0;
            idx_q       <= '0;
            wdata_q     <= '0;
            rsp_data_q  <= '0;
            rsp_stamp_q <= '0;
            opts_q      <= '0;
        end else begin
            if (state == ST_IDLE && in_valid) begin
                hdr_q   <= in_hdr;
                op_q    <= in_opcode;
                tgt_q   <= in_target;
                idx_q   <= in_index;
                wdata_q <= in_data;
            end
            if (state == ST_DECODE) begin
                rsp_stamp_q <= '0;
                rsp_data_q  <= {{PAD_W{1'b0}}, opts_q};
            end
            if (state == ST_OPT_WR)   opts_q      <= wdata_q[OPT_W-1:0];
            if (state == ST_TBL_WAIT) rsp_data_q  <= rt_rdata;
            if (state == ST_CNT_RD)   rsp_stamp_q <= ts;
            if (state == ST_CNT_WAIT) rsp_data_q  <= cnt_rdata;
        end
    end

    // Outputs
    always_comb begin
        in_ready   = 1'b0;
        out_valid  = 1'b0;
        out_hdr    = hdr_q;
        out_opcode = op_q;
        out_target = tgt_q;
        out_index  = idx_q;
        out_data   = wdata_q;
        out_stamp  = '0;
        rt_req     = 1'b0;
        rt_we      = 1'b0;
        cnt_rd     = 1'b0;
        unique case (state)
            ST_IDLE:     in_ready = 1'b1;
            ST_FWD:      out_valid = 1'b1;
            ST_TBL_WR: begin
                rt_req = 1'b1;
                rt_we  = 1'b1;
            end
            ST_TBL_RD:   rt_req = 1'b1;
            ST_CNT_RD:   cnt_rd = 1'b1;
            ST_REPLY: begin
                out_valid  = 1'b1;
                out_hdr    = CTRL_HDR;
                out_opcode = op_q | OPC_RSP_FLAG;
                out_target = port_id;
                out_data   = rsp_data_q;
                out_stamp  = rsp_stamp_q;
            end
            default: ;
        endcase
    end

    assign rt_addr    = idx_q;
    assign rt_wdata   = wdata_q;
    assign cnt_idx    = idx_q;
    assign cnt_per_vc = (op_q == OPC_VC_CNT);
    assign hw_opts    = opts_q;

    // R2
    disabled_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && !ctrl_en) |=> (state == ST_IDLE && !out_valid));

    // R3
    forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && is_ctrl && ctrl_en && !for_me)
            |=> (out_valid && out_opcode == $past(op_q) && out_target == $past(tgt_q)));

    // R4
    tbl_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_req |=> !rt_req);

    // R8
    stamp_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rd |=> (rsp_stamp_q == $past(ts)));

    // R9
    reply_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hdr == CTRL_HDR));

    // R11
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R11
    one_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

endmodule

// File: tb/ctl_cell_engine_test.sv
`timescale 1ns/1ps
module ctl_cell_engine_test;

    localparam logic [23:0] CH   = 24'h00ABC1;
    localparam logic [7:0]  PORT = 8'h03;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_en = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_hdr = '0;
    logic [7:0]  in_opcode = '0, in_target = '0, in_index = '0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic [23:0] out_hdr;
    logic [7:0]  out_opcode, out_target, out_index;
    logic [31:0] out_data;
    logic [7:0]  out_stamp;
    logic        rt_req, rt_we, cnt_rd, cnt_per_vc;
    logic [7:0]  rt_addr, cnt_idx, hw_opts;
    logic [31:0] rt_wdata, rt_rdata, cnt_rdata;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ctl_cell_engine #(.HDR_W(24), .CTRL_HDR(CH), .IDX_W(8), .DATA_W(32),
                      .TS_W(8), .OPT_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .port_id(PORT), .ctrl_en(ctrl_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_hdr(in_hdr),
        .in_opcode(in_opcode), .in_target(in_target), .in_index(in_index),
        .in_data(in_data), .out_valid(out_valid), .out_hdr(out_hdr),
        .out_opcode(out_opcode), .out_target(out_target), .out_index(out_index),
        .out_data(out_data), .out_stamp(out_stamp), .rt_req(rt_req),
        .rt_we(rt_we), .rt_addr(rt_addr), .rt_wdata(rt_wdata),
        .rt_rdata(rt_rdata), .cnt_rd(cnt_rd), .cnt_per_vc(cnt_per_vc),
        .cnt_idx(cnt_idx), .cnt_rdata(cnt_rdata), .hw_opts(hw_opts)
    );

    // Bench cycle counter: cycles since reset release (R8 model)
    logic [7:0] bc;
    always @(posedge clk or negedge rst_n)
        if (!rst_n) bc <= '0; else bc <= bc + 8'd1;

    // Routing table environment
    logic [31:0] mem [256];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 32'h5A00_0000 | i;
            rt_rdata <= '0;
        end else if (rt_req) begin
            if (rt_we) mem[rt_addr] <= rt_wdata;
            rt_rdata <= mem[rt_addr];
        end
    end

    // Counter bank environment: value encodes its read cycle
    logic [7:0] snap;
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt_rdata <= '0;
            snap      <= '0;
        end else if (cnt_rd) begin
            cnt_rdata <= {cnt_per_vc ? 8'hC0 : 8'h10, bc, 8'h00, cnt_idx};
            snap      <= bc;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    typedef struct {
        logic [7:0]  op;
        logic [7:0]  tgt;
        logic [7:0]  idx;
        logic [31:0] data;
        bit          is_cnt;
        bit          is_fwd;
        string       req;
    } exp_t;
    exp_t q[$];

    logic [31:0] shadow [256];
    logic [7:0]  opts_sh = '0;

    // Monitor: pop and compare each output cell
    always @(negedge clk) begin
        if (rst_n && out_valid && !finished) begin
            if (q.size() == 0) begin
                chk(0, "R1/R2/R4/R10", "unexpected output opcode", {24'h0, out_opcode}, 32'h0);
            end else begin
                exp_t e;
                logic [31:0] ed;
                logic [7:0]  es;
                e = q.pop_front();
                es = e.is_cnt ? snap : 8'h00;
                ed = e.is_cnt ? {e.op == 8'h86 ? 8'hC0 : 8'h10, snap, 8'h00, e.idx} : e.data;
                chk(out_hdr == CH, "R9", {e.req, " hdr"}, {8'h0, out_hdr}, {8'h0, CH});
                chk(out_opcode == e.op && out_target == e.tgt && out_index == e.idx,
                    "R9", {e.req, " op/tgt/idx"},
                    {8'h0, out_opcode, out_target, out_index}, {8'h0, e.op, e.tgt, e.idx});
                chk(out_data == ed, e.req, "data", out_data, ed);
                chk(out_stamp == es, "R8", {e.req, " stamp"}, {24'h0, out_stamp}, {24'h0, es});
            end
        end
    end

    // Driver: model the expectation, then present the cell
    task automatic send(input logic [23:0] h, input logic [7:0] op, input logic [7:0] tg,
                        input logic [7:0] ix, input logic [31:0] d, input string req);
        exp_t e;
        e.op = op; e.tgt = PORT; e.idx = ix; e.data = '0; e.is_cnt = 0; e.is_fwd = 0; e.req = req;
        if (h == CH && ctrl_en) begin
            if (tg != PORT) begin
                e.tgt = tg; e.data = d; e.is_fwd = 1; q.push_back(e);
            end else begin
                case (op)
                    8'h01: begin e.op = op | 8'h80; e.data = shadow[ix]; q.push_back(e); end
                    8'h02: shadow[ix] = d;
                    8'h03: opts_sh = d[7:0];
                    8'h04: begin e.op = op | 8'h80; e.data = {24'h0, opts_sh}; q.push_back(e); end
                    8'h05, 8'h06: begin e.op = op | 8'h80; e.is_cnt = 1; q.push_back(e); end
                    default: ;
                endcase
            end
        end
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_hdr = h; in_opcode = op; in_target = tg; in_index = ix; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(0, "R11", "watchdog expired", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = 32'h5A00_0000 | i;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(in_ready == 1'b1, "R11", "in_ready after reset", {31'h0, in_ready}, 32'h1);
        chk(out_valid == 1'b0, "R11", "out_valid after reset", {31'h0, out_valid}, 32'h0);
        chk(hw_opts == 8'h00, "R11", "hw_opts after reset", {24'h0, hw_opts}, 32'h0);

        // R5 / R4 table read, write, read back
        send(CH, 8'h01, PORT, 8'h05, 32'h0, "R5");
        send(CH, 8'h02, PORT, 8'h05, 32'hDEAD_BEEF, "R4");
        send(CH, 8'h01, PORT, 8'h05, 32'h0, "R4");
        send(CH, 8'h02, PORT, 8'hFF, 32'h1234_5678, "R4");
        send(CH, 8'h01, PORT, 8'hFF, 32'h0, "R5");

        // R6 option write and read
        send(CH, 8'h03, PORT, 8'h00, 32'hFFFF_FFA5, "R6");
        chk(hw_opts == 8'hA5, "R6", "hw_opts after write", {24'h0, hw_opts}, 32'hA5);
        send(CH, 8'h04, PORT, 8'h11, 32'h0, "R6");

        // R7 / R8 counter reads
        send(CH, 8'h05, PORT, 8'h02, 32'h0, "R7");
        send(CH, 8'h06, PORT, 8'h09, 32'h0, "R7");

        // R2 disabled reception
        ctrl_en = 1'b0;
        send(CH, 8'h02, PORT, 8'h05, 32'h1111_1111, "R2");
        send(CH, 8'h03, PORT, 8'h00, 32'h0000_003C, "R2");
        send(CH, 8'h04, PORT, 8'h00, 32'h0, "R2");
        chk(hw_opts == 8'hA5, "R2", "hw_opts while disabled", {24'h0, hw_opts}, 32'hA5);
        ctrl_en = 1'b1;
        send(CH, 8'h01, PORT, 8'h05, 32'h0, "R2");

        // R1 non-control header
        send(24'h00ABC0, 8'h02, PORT, 8'h05, 32'h2222_2222, "R1");
        send(24'h10ABC1, 8'h04, PORT, 8'h00, 32'h0, "R1");
        send(CH, 8'h01, PORT, 8'h05, 32'h0, "R1");

        // R3 forwarding toward another port
        send(CH, 8'h02, 8'h07, 8'h05, 32'h3333_3333, "R3");
        send(CH, 8'h04, 8'h00, 8'h42, 32'hCAFE_0001, "R3");
        send(CH, 8'h01, PORT, 8'h05, 32'h0, "R3");

        // R10 unknown opcodes
        send(CH, 8'h07, PORT, 8'h05, 32'h4444_4444, "R10");
        send(CH, 8'h83, PORT, 8'h00, 32'h0000_0077, "R10");
        send(CH, 8'h00, PORT, 8'h05, 32'h5555_5555, "R10");
        chk(hw_opts == 8'hA5, "R10", "hw_opts after unknown op", {24'h0, hw_opts}, 32'hA5);
        send(CH, 8'h01, PORT, 8'h05, 32'h0, "R10");

        // R8 timestamp wrap
        repeat (300) @(negedge clk);
        send(CH, 8'h06, PORT, 8'h80, 32'h0, "R8");
        send(CH, 8'h05, PORT, 8'h01, 32'h0, "R8");

        repeat (10) @(negedge clk);
        chk(q.size() == 0, "R9", "replies outstanding", q.size(), 32'h0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule